// File: doc/BRIEF.md
# Encoded-Ratio Clock Prescaler

This block produces a clock-enable pulse for the kernel of a low-power serial peripheral. A 4-bit selector code picks one of twelve divide ratios from a non-uniform table (1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256). The pulse is one input-clock cycle wide and repeats once every N cycles, where N is the selected ratio. Downstream baud logic treats this pulse as its clock. The four codes above the table are reserved and give the largest ratio.

The selector is held in a small register. Software writes it through a data-plus-strobe port and reads it back unchanged. Writes are accepted only while the peripheral is disabled. While the peripheral is disabled the divider counter is held at zero and no pulse is produced. The first pulse after enabling therefore comes exactly N cycles later.

Top module: `enc_clk_prescaler`

## Requirements
- R1: After reset the stored code is 0 and the readback shows 0. Once enabled, the block divides by 1, so the tick is high on every cycle.
- R2: Codes 0 to 11 select the ratios 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128 and 256, in that order.
- R3: Codes 12, 13, 14 and 15 are reserved and select a ratio of 256.
- R4: A write strobe seen at a clock edge while the peripheral-enable input is low stores the 4-bit data. The readback shows the new value from the next cycle on.
- R5: A write strobe seen while the peripheral-enable input is high is ignored. The stored code, the readback and the tick period stay unchanged.
- R6: While enabled with ratio N, the tick is high for exactly one cycle in every N cycles. The interval between consecutive ticks is N.
- R7: While the peripheral-enable input is low, the tick is low and the counter is cleared. The first tick after enable rises falls in the N-th enabled cycle, counting the first enabled cycle as 1.
- R8: The readback returns the stored code exactly as written, including reserved codes 12 to 15.
- R9: The counter is 8 bits wide. It counts from 0 to N-1 and returns to 0 on the cycle the tick is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; high runs the divider and locks the selector |
| cfg_wdata | input | 4 | Selector code to write |
| cfg_we | input | 1 | Write strobe for the selector |
| cfg_rdata | output | 4 | Readback of the stored selector code |
| tick_o | output | 1 | Single-cycle enable pulse at the divided rate |

## Verification
A write attempt and a divider tick can land in the same cycle while the peripheral is enabled. The locked write must not disturb the counter's period or the stored code. To provoke this, the bench issues write strobes with random data on every cycle of an enabled window that spans two full periods. It then checks that exactly two ticks appear, at the expected positions, and that the readback is still the code written before enabling. A second overlap occurs at the cycle where enable rises, which is also the last cycle in which a write is still accepted. The bench writes on the disabled cycle just before enabling and checks that the ratio used by the divider is the newly written one.

// File: rtl/enc_clk_prescaler_pkg.sv
package enc_clk_prescaler_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned CNT_W  = 8;

  typedef logic [CODE_W-1:0] sel_code_t;
  typedef logic [CNT_W-1:0]  div_cnt_t;

  // Terminal count (ratio minus one) for a selector code.
  function automatic div_cnt_t term_of(input sel_code_t code);
    div_cnt_t t;
    case (code)
      4'd0:    t = div_cnt_t'(0);
      4'd1:    t = div_cnt_t'(1);
      4'd2:    t = div_cnt_t'(3);
      4'd3:    t = div_cnt_t'(5);
      4'd4:    t = div_cnt_t'(7);
      4'd5:    t = div_cnt_t'(9);
      4'd6:    t = div_cnt_t'(11);
      4'd7:    t = div_cnt_t'(15);
      4'd8:    t = div_cnt_t'(31);
      4'd9:    t = div_cnt_t'(63);
      4'd10:   t = div_cnt_t'(127);
      default: t = div_cnt_t'(255);
    endcase
    return t;
  endfunction
endpackage

// File: rtl/enc_clk_prescaler_sel_reg.sv
module enc_clk_prescaler_sel_reg
  import enc_clk_prescaler_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lock,
  input  logic      we,
  input  sel_code_t wdata,
  output sel_code_t code_q,
  output logic      wr_accept
);
  assign wr_accept = we && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         code_q <= '0;
    else if (wr_accept) code_q <= wdata;
  end
endmodule

// File: rtl/enc_clk_prescaler_decode.sv
module enc_clk_prescaler_decode
  import enc_clk_prescaler_pkg::*;
(
  input  sel_code_t code,
  output div_cnt_t  term,
  output logic      reserved
);
  localparam sel_code_t LAST_VALID = sel_code_t'(11);

  assign term     = term_of(code);
  assign reserved = (code > LAST_VALID);
endmodule

// File: rtl/enc_clk_prescaler_counter.sv
module enc_clk_prescaler_counter
  import enc_clk_prescaler_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  div_cnt_t term,
  output div_cnt_t cnt_q,
  output logic     wrap
);
  assign wrap = run && (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + div_cnt_t'(1);
  end
endmodule

// File: rtl/enc_clk_prescaler.sv
module enc_clk_prescaler
  import enc_clk_prescaler_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_en,
  input  logic [CODE_W-1:0] cfg_wdata,
  input  logic              cfg_we,
  output logic [CODE_W-1:0] cfg_rdata,
  output logic              tick_o
);
  sel_code_t code_q;
  logic      wr_accept;
  div_cnt_t  term_cnt;
  logic      code_reserved;
  div_cnt_t  cnt_q;
  logic      wrap_evt;

  enc_clk_prescaler_sel_reg u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock      (periph_en),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .code_q    (code_q),
    .wr_accept (wr_accept)
  );

  enc_clk_prescaler_decode u_dec (
    .code     (code_q),
    .term     (term_cnt),
    .reserved (code_reserved)
  );

  enc_clk_prescaler_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (periph_en),
    .term  (term_cnt),
    .cnt_q (cnt_q),
    .wrap  (wrap_evt)
  );

  assign cfg_rdata = code_q;
  assign tick_o    = wrap_evt;
endmodule

// File: rtl/enc_clk_prescaler_chk.sv
module enc_clk_prescaler_chk
  import enc_clk_prescaler_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      periph_en,
  input logic      cfg_we,
  input sel_code_t cfg_wdata,
  input sel_code_t cfg_rdata,
  input logic      tick_o,
  input div_cnt_t  cnt_q,
  input div_cnt_t  term_cnt,
  input logic      code_reserved
);
  p_tick_off_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |-> !tick_o);

  p_cnt_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |=> cnt_q == '0);

  p_write_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && periph_en) |=> cfg_rdata == $past(cfg_rdata));

  p_write_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !periph_en) |=> cfg_rdata == $past(cfg_wdata));

  p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_cnt);

  p_wrap_to_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_q == '0);

  p_reserved_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_reserved |-> term_cnt == div_cnt_t'(255));
endmodule

bind enc_clk_prescaler enc_clk_prescaler_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .periph_en     (periph_en),
  .cfg_we        (cfg_we),
  .cfg_wdata     (cfg_wdata),
  .cfg_rdata     (cfg_rdata),
  .tick_o        (tick_o),
  .cnt_q         (cnt_q),
  .term_cnt      (term_cnt),
  .code_reserved (code_reserved)
);

// File: tb/enc_clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module enc_clk_prescaler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       periph_en = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_rdata;
  logic       tick_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  enc_clk_prescaler dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .periph_en (periph_en),
    .cfg_wdata (cfg_wdata),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .tick_o    (tick_o)
  );

  // Expected ratio, restated arithmetically.
  function automatic int exp_ratio(input int code);
    if (code == 0)  return 1;
    if (code <= 6)  return 2 * code;
    if (code == 7)  return 16;
    if (code <= 11) return 32 << (code - 8);
    return 256;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_code(input int code);
    @(negedge clk);
    periph_en = 1'b0;
    cfg_we    = 1'b1;
    cfg_wdata = code[3:0];
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Enable for 2N cycles; optional random write attempts every cycle.
  task automatic run_window(input int code, input bit noise, input string req);
    int n = exp_ratio(code);
    int ticks = 0;
    int first = 0;
    int second = 0;
    periph_en = 1'b1;
    for (int k = 1; k <= 2 * n; k++) begin
      if (noise) begin
        cfg_we    = 1'b1;
        cfg_wdata = 4'($urandom);
      end
      #1;
      if (tick_o) begin
        ticks++;
        if (first == 0) first = k; else if (second == 0) second = k;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    check(first == n, {req, " R7 first tick"}, first, n);
    check(second - first == n, {req, " R6 interval"}, second - first, n);
    check(ticks == 2, {req, " R6 tick count"}, ticks, 2);
    check(cfg_rdata == code[3:0], {req, " readback"}, cfg_rdata, code);
    periph_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    #1;
    check(tick_o == 1'b0, "R7 tick low in reset/disabled", tick_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rdata == 4'd0, "R1 reset code", cfg_rdata, 0);
    // R1: divide by 1 straight after reset
    periph_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #1;
      check(tick_o == 1'b1, "R1 tick every cycle", tick_o, 1);
      @(negedge clk);
    end
    periph_en = 1'b0;
    @(negedge clk);
    // R2, R3, R8: every code, written on the cycle just before enabling
    for (int c = 0; c < 16; c++) begin
      write_code(c);
      check(cfg_rdata == 4'(c), (c > 11) ? "R8 reserved readback" : "R4 readback", cfg_rdata, c);
      run_window(c, 1'b0, (c > 11) ? "R3" : "R2");
    end
    // R5: locked writes overlapping ticks
    for (int i = 0; i < 6; i++) begin
      int c = $urandom_range(0, 9);
      write_code(c);
      run_window(c, 1'b1, "R5 locked write");
    end
    // R7: disable mid-count, then restart from zero
    for (int i = 0; i < 4; i++) begin
      int c = $urandom_range(2, 8);
      int m = $urandom_range(1, exp_ratio(c) - 1);
      write_code(c);
      periph_en = 1'b1;
      repeat (m) @(negedge clk);
      periph_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
        #1;
        check(tick_o == 1'b0, "R7 tick low while disabled", tick_o, 0);
        @(negedge clk);
      end
      run_window(c, 1'b0, "R7 restart");
    end
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule